// File: doc/BRIEF.md
# Two-Deep Buffered Input Capture Channel

This block is one input-capture channel of a timer. A free-running count is presented on its input. Each time an already edge-qualified event strobe arrives, the channel records that count. A capture slot takes the newest value. A holding slot behind it keeps the value that came before. The bus reads either slot with a one-cycle read strobe. Each slot carries a full flag that is set when an event writes it and cleared when the bus reads it.

A per-channel no-overwrite enable decides whether unread data may be displaced.

- With the enable low, every event pushes the capture value into the holding slot and stores the new count.
- With the enable high, an event writes only into a slot that is free. When both slots hold unread data, the event is dropped and a sticky lost-event flag is raised.

A mode input selects between latch mode and queue mode. In queue mode, a bus read of the holding slot produces a one-cycle strobe. A neighbouring pulse accumulator uses this strobe to latch its count. In latch mode, holding-slot reads produce no strobe.

Top module: `bufcap_channel`

## Requirements
- R1: A synchronous active-low reset clears both slot values to 0, both full flags, the lost-event flag and the strobe.
- R2: With no-overwrite low, an event copies the capture value into the holding slot and loads the timer count into the capture slot. The capture full flag becomes 1. The holding full flag takes the capture full flag's prior value, or 0 if the capture slot is read in that same cycle.
- R3: With no-overwrite high and the capture slot free, an event loads only the capture slot. The holding value and the holding full flag are unchanged. A slot counts as free when it is empty or is read in the same cycle.
- R4: With no-overwrite high, the capture slot full and not being read, and the holding slot free, an event shifts the capture value into the holding slot and then stores the new count. Both full flags become 1.
- R5: With no-overwrite high and both slots full and not being read, an event is dropped. Both values and both flags stay unchanged, and the lost-event flag becomes 1.
- R6: The lost-event flag stays set until the holding slot is read. That read clears the flag on the following edge.
- R7: A read of a slot with no effect from an event clears that slot's full flag on the next edge. The slot's value is not changed.
- R8: All outputs are registers. A read issued in the same cycle as an event therefore returns the value held before that event.
- R9: The accumulator-latch strobe is 1 for exactly the one cycle after a holding-slot read made with queue mode selected (mode input = 1). It stays 0 after reads in latch mode (mode input = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| timer_cnt | input | 16 | Free-running timer count |
| capt_evt | input | 1 | Qualified capture event strobe |
| queue_mode | input | 1 | 1 = queue mode, 0 = latch mode |
| no_ovw | input | 1 | 1 = never displace unread data |
| rd_cap | input | 1 | Bus read strobe of the capture slot |
| rd_hold | input | 1 | Bus read strobe of the holding slot |
| cap_val | output | 16 | Capture slot value |
| hold_val | output | 16 | Holding slot value |
| cap_full | output | 1 | Capture slot holds unread data |
| hold_full | output | 1 | Holding slot holds unread data |
| lost_evt | output | 1 | Sticky flag: an event was dropped |
| acc_latch | output | 1 | Accumulator latch strobe (queue mode) |

## Verification
Every result is due exactly one clock edge after the stimulus that causes it: slot values, flags, the lost flag and the latch strobe are all registered once. The bench drives each vector after a falling edge and samples one time unit after the following rising edge. It compares every output there. For the same-cycle read case, the bench also samples the outputs just before that edge to confirm that the pre-event value is what the bus sees.

// File: rtl/bufcap_pkg.sv
package bufcap_pkg;

    typedef enum logic [1:0] {
        ACT_NONE     = 2'd0,
        ACT_CAP_ONLY = 2'd1,
        ACT_SHIFT    = 2'd2,
        ACT_DROP     = 2'd3
    } bufcap_act_e;

endpackage

// File: rtl/bufcap_decide.sv
module bufcap_decide
    import bufcap_pkg::*;
(
    input  logic        capt_evt,
    input  logic        no_ovw,
    input  logic        cap_full,
    input  logic        hold_full,
    input  logic        rd_cap,
    input  logic        rd_hold,
    output bufcap_act_e act
);
    logic cap_free;
    logic hold_free;

    always_comb begin
        // a slot read in this cycle counts as free
        cap_free  = !cap_full  || rd_cap;
        hold_free = !hold_full || rd_hold;
        if (!capt_evt) begin
            act = ACT_NONE;
        end else if (!no_ovw) begin
            act = ACT_SHIFT;
        end else if (cap_free) begin
            act = ACT_CAP_ONLY;
        end else if (hold_free) begin
            act = ACT_SHIFT;
        end else begin
            act = ACT_DROP;
        end
    end
endmodule

// File: rtl/bufcap_store.sv
module bufcap_store
    import bufcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bufcap_act_e      act,
    input  logic [CNT_W-1:0] timer_cnt,
    input  logic             rd_cap,
    input  logic             rd_hold,
    output logic [CNT_W-1:0] cap_val,
    output logic [CNT_W-1:0] hold_val,
    output logic             cap_full,
    output logic             hold_full,
    output logic             lost_evt
);
    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] hold;
        logic             cap_full;
        logic             hold_full;
        logic             lost;
    } slot_st_t;

    slot_st_t st_d;
    slot_st_t st_q;

    always_comb begin
        st_d = st_q;
        if (rd_cap) begin
            st_d.cap_full = 1'b0;
        end
        if (rd_hold) begin
            st_d.hold_full = 1'b0;
            st_d.lost      = 1'b0;
        end
        case (act)
            ACT_SHIFT: begin
                st_d.hold      = st_q.cap;
                st_d.hold_full = st_q.cap_full && !rd_cap;
                st_d.cap       = timer_cnt;
                st_d.cap_full  = 1'b1;
            end
            ACT_CAP_ONLY: begin
                st_d.cap      = timer_cnt;
                st_d.cap_full = 1'b1;
            end
            ACT_DROP: begin
                st_d.lost = 1'b1;
            end
            default: ;
        endcase
        if (!rst_n) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cap_val   = st_q.cap;
    assign hold_val  = st_q.hold;
    assign cap_full  = st_q.cap_full;
    assign hold_full = st_q.hold_full;
    assign lost_evt  = st_q.lost;
endmodule

// File: rtl/bufcap_strobe.sv
module bufcap_strobe (
    input  logic clk,
    input  logic rst_n,
    input  logic queue_mode,
    input  logic rd_hold,
    output logic acc_latch
);
    logic strobe_d;
    logic strobe_q;

    always_comb begin
        strobe_d = queue_mode && rd_hold;
        if (!rst_n) begin
            strobe_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        strobe_q <= strobe_d;
    end

    assign acc_latch = strobe_q;
endmodule

// File: rtl/bufcap_channel.sv
module bufcap_channel
    import bufcap_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] timer_cnt,
    input  logic             capt_evt,
    input  logic             queue_mode,
    input  logic             no_ovw,
    input  logic             rd_cap,
    input  logic             rd_hold,
    output logic [CNT_W-1:0] cap_val,
    output logic [CNT_W-1:0] hold_val,
    output logic             cap_full,
    output logic             hold_full,
    output logic             lost_evt,
    output logic             acc_latch
);
    bufcap_act_e act;

    bufcap_decide u_decide (
        .capt_evt (capt_evt),
        .no_ovw   (no_ovw),
        .cap_full (cap_full),
        .hold_full(hold_full),
        .rd_cap   (rd_cap),
        .rd_hold  (rd_hold),
        .act      (act)
    );

    bufcap_store #(.CNT_W(CNT_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (act),
        .timer_cnt(timer_cnt),
        .rd_cap   (rd_cap),
        .rd_hold  (rd_hold),
        .cap_val  (cap_val),
        .hold_val (hold_val),
        .cap_full (cap_full),
        .hold_full(hold_full),
        .lost_evt (lost_evt)
    );

    bufcap_strobe u_strobe (
        .clk       (clk),
        .rst_n     (rst_n),
        .queue_mode(queue_mode),
        .rd_hold   (rd_hold),
        .acc_latch (acc_latch)
    );
endmodule

// File: rtl/bufcap_chk.sv
module bufcap_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] timer_cnt,
    input logic             capt_evt,
    input logic             queue_mode,
    input logic             no_ovw,
    input logic             rd_cap,
    input logic             rd_hold,
    input logic [CNT_W-1:0] cap_val,
    input logic [CNT_W-1:0] hold_val,
    input logic             cap_full,
    input logic             hold_full,
    input logic             lost_evt,
    input logic             acc_latch
);
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (cap_val == '0 && hold_val == '0 && !cap_full && !hold_full
                    && !lost_evt && !acc_latch));

    a_r2_push_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        (capt_evt && !no_ovw) |=> (hold_val == $past(cap_val)
                                   && cap_val == $past(timer_cnt) && cap_full));

    a_r4_shift_fills_both: assert property (@(posedge clk) disable iff (!rst_n)
        (capt_evt && no_ovw && cap_full && !rd_cap && !hold_full)
        |=> (cap_full && hold_full && hold_val == $past(cap_val)));

    a_r5_drop_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (capt_evt && no_ovw && cap_full && hold_full && !rd_cap && !rd_hold)
        |=> ($stable(cap_val) && $stable(hold_val) && lost_evt));

    a_r7_read_clears_cap: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cap && !capt_evt) |=> (!cap_full && $stable(cap_val)));

    a_r9_strobe_after_queue_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && queue_mode) |=> acc_latch);

    a_r9_no_strobe_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_hold && queue_mode) |=> !acc_latch);
endmodule

bind bufcap_channel bufcap_chk #(.CNT_W(CNT_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .timer_cnt (timer_cnt),
    .capt_evt  (capt_evt),
    .queue_mode(queue_mode),
    .no_ovw    (no_ovw),
    .rd_cap    (rd_cap),
    .rd_hold   (rd_hold),
    .cap_val   (cap_val),
    .hold_val  (hold_val),
    .cap_full  (cap_full),
    .hold_full (hold_full),
    .lost_evt  (lost_evt),
    .acc_latch (acc_latch)
);

// File: tb/bufcap_channel_tb_top.sv
module bufcap_channel_tb_top;

    typedef struct packed {
        logic        ev;
        logic [15:0] tc;
        logic        nov;
        logic        qm;
        logic        rc;
        logic        rh;
        logic [15:0] e_cap;
        logic [15:0] e_hold;
        logic        e_cf;
        logic        e_hf;
        logic        e_lost;
        logic        e_st;
    } vec_t;

    function automatic vec_t mk(logic ev, logic [15:0] tc, logic nov, logic qm,
                                logic rc, logic rh, logic [15:0] ec, logic [15:0] eh,
                                logic cf, logic hf, logic lo, logic st);
        vec_t v;
        v = '{ev, tc, nov, qm, rc, rh, ec, eh, cf, hf, lo, st};
        return v;
    endfunction

    localparam int NVEC = 17;
    localparam vec_t TBL [NVEC] = '{
        mk(1, 16'h1111, 0, 0, 0, 0, 16'h1111, 16'h0000, 1, 0, 0, 0), // R2 first push
        mk(1, 16'h2222, 0, 0, 0, 0, 16'h2222, 16'h1111, 1, 1, 0, 0), // R2
        mk(1, 16'h3333, 0, 0, 0, 0, 16'h3333, 16'h2222, 1, 1, 0, 0), // R2 overwrite
        mk(0, 16'h0000, 0, 1, 0, 1, 16'h3333, 16'h2222, 1, 0, 0, 1), // R7 R9 queue read
        mk(0, 16'h0000, 0, 1, 0, 0, 16'h3333, 16'h2222, 1, 0, 0, 0), // R9 one cycle
        mk(1, 16'h4444, 1, 0, 0, 0, 16'h4444, 16'h3333, 1, 1, 0, 0), // R4 shift
        mk(1, 16'h5555, 1, 0, 0, 0, 16'h4444, 16'h3333, 1, 1, 1, 0), // R5 drop
        mk(0, 16'h0000, 1, 0, 1, 0, 16'h4444, 16'h3333, 0, 1, 1, 0), // R7 R6 stays
        mk(1, 16'h6666, 1, 0, 0, 0, 16'h6666, 16'h3333, 1, 1, 1, 0), // R3 cap only
        mk(0, 16'h0000, 1, 0, 0, 1, 16'h6666, 16'h3333, 1, 0, 0, 0), // R6 R9 latch read
        mk(1, 16'h7777, 1, 0, 1, 0, 16'h7777, 16'h3333, 1, 0, 0, 0), // R3 freed by read
        mk(1, 16'h8888, 1, 0, 0, 0, 16'h8888, 16'h7777, 1, 1, 0, 0), // R4
        mk(1, 16'h9999, 1, 1, 0, 1, 16'h9999, 16'h8888, 1, 1, 0, 1), // R4 R9 hold freed
        mk(1, 16'hAAAA, 1, 1, 0, 0, 16'h9999, 16'h8888, 1, 1, 1, 0), // R5
        mk(1, 16'hBBBB, 1, 0, 0, 1, 16'hBBBB, 16'h9999, 1, 1, 0, 0), // R4 R6
        mk(1, 16'hCCCC, 0, 0, 1, 0, 16'hCCCC, 16'hBBBB, 1, 0, 0, 0), // R2 same-cycle read
        mk(1, 16'hDDDD, 1, 0, 0, 0, 16'hDDDD, 16'hCCCC, 1, 1, 0, 0)  // R4
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] timer_cnt = '0;
    logic        capt_evt = 1'b0;
    logic        queue_mode = 1'b0;
    logic        no_ovw = 1'b0;
    logic        rd_cap = 1'b0;
    logic        rd_hold = 1'b0;
    logic [15:0] cap_val;
    logic [15:0] hold_val;
    logic        cap_full;
    logic        hold_full;
    logic        lost_evt;
    logic        acc_latch;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bufcap_channel #(.CNT_W(16)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .timer_cnt (timer_cnt),
        .capt_evt  (capt_evt),
        .queue_mode(queue_mode),
        .no_ovw    (no_ovw),
        .rd_cap    (rd_cap),
        .rd_hold   (rd_hold),
        .cap_val   (cap_val),
        .hold_val  (hold_val),
        .cap_full  (cap_full),
        .hold_full (hold_full),
        .lost_evt  (lost_evt),
        .acc_latch (acc_latch)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string req, vec_t v);
        chk({req, " cap_val"},   cap_val,           v.e_cap);
        chk({req, " hold_val"},  hold_val,          v.e_hold);
        chk({req, " cap_full"},  {15'd0, cap_full},  {15'd0, v.e_cf});
        chk({req, " hold_full"}, {15'd0, hold_full}, {15'd0, v.e_hf});
        chk({req, " lost_evt"},  {15'd0, lost_evt},  {15'd0, v.e_lost});
        chk({req, " acc_latch"}, {15'd0, acc_latch}, {15'd0, v.e_st});
    endtask

    task automatic apply(vec_t v);
        @(negedge clk);
        capt_evt   = v.ev;
        timer_cnt  = v.tc;
        no_ovw     = v.nov;
        queue_mode = v.qm;
        rd_cap     = v.rc;
        rd_hold    = v.rh;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        vec_t rv;
        rv = mk(0, 0, 0, 0, 0, 0, 16'h0000, 16'h0000, 0, 0, 0, 0);
        // R1: reset state
        repeat (2) @(posedge clk);
        #1;
        check_all("R1 reset", rv);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            apply(TBL[i]);
            check_all($sformatf("vector %0d", i), TBL[i]);
        end

        // R8: event with same-cycle read returns pre-event value
        @(negedge clk);
        capt_evt = 1'b1; timer_cnt = 16'hEEEE; no_ovw = 1'b0;
        rd_cap = 1'b1; rd_hold = 1'b0; queue_mode = 1'b0;
        #2;
        chk("R8 read sees old cap", cap_val, 16'hDDDD);
        @(posedge clk);
        #1;
        chk("R8 new cap after edge", cap_val, 16'hEEEE);
        chk("R8 hold takes read value", hold_val, 16'hDDDD);
        chk("R2 hold_full cleared by same-cycle read", {15'd0, hold_full}, 16'd0);

        // R1: reset mid-run with data present
        @(negedge clk);
        capt_evt = 1'b0; rd_cap = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_all("R1 mid-run reset", rv);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule